// File: doc/BRIEF.md
# Video Raster Format Detector

This block watches a 10-bit parallel video word stream that carries embedded timing reference sequences. It finds each sequence, keeps the H, V and F flags from its final word, and measures the raster in two dimensions: the number of accepted words in one line and the number of lines in one frame. At each frame start it compares the measured pair against a fixed set of standard rasters. Once two frames in a row agree, it reports a structured 5-bit format code and raises a lock flag. Rasters that differ only by the 1000/1001 clock ratio have identical word and line counts, so they map to the same code.

Software steers detection through a two-entry register space. It can leave the block in automatic mode, narrow it to the HD or SD family, or pin it to exactly one format code. Any write to the control entry throws away the measurement in progress and the current lock. The stream side has a valid qualifier and no ready signal: the detector takes one word in every cycle where `vid_valid` is high, so it never applies back-pressure. Words with `vid_valid` low are neither counted nor searched for sequences.

Two parameters divide the table geometry, words per line and lines per frame, by integer factors. This lets the same logic run on shortened rasters. At the default of 1 the full standard sizes apply.

Top module: `vfd_raster_detect`

## Requirements
- R1: After reset, `fmt_code` is 00000, `locked` is 0, the H/V/F flags are 0 and both register entries read 00h.
- R2: A timing sequence is four accepted words 3FFh, 000h, 000h, XYZ. In XYZ, bit 6 is H, bit 7 is V and bit 8 is F, with 1 meaning active. These load into `flag_h`/`flag_v`/`flag_f` on the edge that accepts XYZ and hold until the next sequence. Words with `vid_valid` low are ignored.
- R3: Words per line is the count of accepted words from one sequence with H=1 up to the next one. Lines per frame is the count of H=1 sequences between frame starts. A frame start is a sequence with V=0 and F=0 whose preceding sequence had V=1.
- R4: The allowed entries, as lines x words giving a code, are: 525x1716 gives 00011, 625x1728 gives 01011, 1125x2200 gives 10010, 1125x2640 gives 11010, and 750x1650 gives 10100. Lines are divided by LINE_DIV and words by WORD_DIV. Code bit 4 means HD, code bit 3 means a 50 Hz raster, and bits 2:0 give the sub-standard.
- R5: The first frame start after reset or restart is discarded. After that, each frame start measures one frame. `locked` rises, and the code shows the entry, when a measurement equals the previous one and matches an allowed entry.
- R6: A single frame that differs from its predecessor, or that matches no allowed entry, clears `locked`, and `fmt_code` reads 00000.
- R7: A nonzero format-select value allows only the entry with that exact code. The value 0 allows all entries.
- R8: The HD-only bit allows only entries with code bit 4 set. The SD-only bit allows only entries with code bit 4 clear. With both bits set, nothing is allowed.
- R9: Register offset 0 is read/write, with bits 4:0 as the format select, bit 5 as HD-only and bit 6 as SD-only; bit 7 reads 0. Offset 1 is read-only, with bits 4:0 as the code, bit 5 as H, bit 6 as V and bit 7 as F. Writes to offset 1 have no effect.
- R10: A write to offset 0 clears `locked` and the code on its edge and restarts the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_valid | input | 1 | Stream word qualifier |
| vid_data | input | 10 | Stream word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register offset |
| reg_wdata | input | 7 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| fmt_code | output | 5 | Detected format code, 0 when not locked |
| locked | output | 1 | Format lock flag |
| flag_h | output | 1 | H from the latest sequence |
| flag_v | output | 1 | V from the latest sequence |
| flag_f | output | 1 | F from the latest sequence |

## Verification
The bench builds the detector with WORD_DIV=50 and LINE_DIV=25. This shrinks every raster to between roughly 700 and 2300 words per frame and the counters to 6 bits, while all five entries stay distinct. With frames this small, the run can step through a lock on every table entry, a drop after a single odd-length frame followed by relock, and each confinement mode. Every run starts from scratch after a register write. Idle cycles with preamble-like data are mixed into the stream to show that only qualified words are counted.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  localparam int NUM_FMT = 5;
  localparam logic [9:0] PRE_ONES = 10'h3FF;
  localparam logic [9:0] PRE_ZERO = 10'h000;
  localparam logic REG_CTRL = 1'b0;

  // packed so that bits [2:0] line up with XYZ bits [8:6]
  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trs_flags_t;

  typedef enum logic [1:0] {
    ACQ_WAIT,   // no frame start seen since restart
    ACQ_ARMED,  // first (partial) frame started, nothing measured yet
    ACQ_TRACK   // a previous full-frame measurement is held
  } acq_t;

  function automatic int ref_lines(int idx);
    case (idx)
      0: return 525;
      1: return 625;
      2: return 1125;
      3: return 1125;
      default: return 750;
    endcase
  endfunction

  function automatic int ref_words(int idx);
    case (idx)
      0: return 1716;
      1: return 1728;
      2: return 2200;
      3: return 2640;
      default: return 1650;
    endcase
  endfunction

  function automatic logic [4:0] ref_code(int idx);
    case (idx)
      0: return 5'b00011;
      1: return 5'b01011;
      2: return 5'b10010;
      3: return 5'b11010;
      default: return 5'b10100;
    endcase
  endfunction

  function automatic int max_words();
    int m = 0;
    for (int i = 0; i < NUM_FMT; i++) if (ref_words(i) > m) m = ref_words(i);
    return m;
  endfunction

  function automatic int max_lines();
    int m = 0;
    for (int i = 0; i < NUM_FMT; i++) if (ref_lines(i) > m) m = ref_lines(i);
    return m;
  endfunction

endpackage

// File: rtl/vfd_trs_detect.sv
module vfd_trs_detect
  import vfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld,
  input  logic [9:0] word,
  output logic       trs_hit,
  output trs_flags_t flags
);

  localparam int HIST = 3;

  logic [9:0] hist [HIST];

  // history of accepted words, hist[0] newest
  generate
    for (genvar g = 0; g < HIST; g++) begin : g_hist
      always_ff @(posedge clk) begin
        if (!rst_n) hist[g] <= '0;
        else if (vld) begin
          if (g == 0) hist[g] <= word;
          else        hist[g] <= hist[g-1];
        end
      end
    end
  endgenerate

  assign trs_hit = vld && (hist[2] == PRE_ONES) && (hist[1] == PRE_ZERO) && (hist[0] == PRE_ZERO);
  assign flags   = trs_flags_t'(word[8:6]);

endmodule

// File: rtl/vfd_geom.sv
module vfd_geom
  import vfd_pkg::*;
#(
  parameter int WCNT_W = 12,
  parameter int LCNT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic              trs_hit,
  input  trs_flags_t        flags,
  output logic              frm_stb,
  output logic [LCNT_W-1:0] frm_lines,
  output logic [WCNT_W-1:0] frm_words
);

  logic [WCNT_W-1:0] wcnt, wcnt_inc, llen;
  logic [LCNT_W-1:0] lcnt;
  logic              last_v;
  logic              eav;

  assign eav      = trs_hit && flags.h;
  assign wcnt_inc = (&wcnt) ? wcnt : wcnt + 1'b1;
  assign frm_stb  = trs_hit && last_v && !flags.v && !flags.f;

  // values as they stand including the current word
  assign frm_words = eav ? wcnt_inc : llen;
  assign frm_lines = (eav && !(&lcnt)) ? lcnt + 1'b1 : lcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt   <= '0;
      llen   <= '0;
      lcnt   <= '0;
      last_v <= 1'b0;
    end else begin
      if (vld) wcnt <= eav ? '0 : wcnt_inc;
      if (eav) llen <= wcnt_inc;
      if (frm_stb)      lcnt <= '0;
      else if (trs_hit) lcnt <= frm_lines;
      if (trs_hit) last_v <= flags.v;
    end
  end

endmodule

// File: rtl/vfd_match.sv
module vfd_match
  import vfd_pkg::*;
#(
  parameter int WORD_DIV = 1,
  parameter int LINE_DIV = 1,
  parameter int WCNT_W   = 12,
  parameter int LCNT_W   = 11
) (
  input  logic [LCNT_W-1:0] lines,
  input  logic [WCNT_W-1:0] words,
  input  logic [4:0]        fmt_sel,
  input  logic              hd_only,
  input  logic              sd_only,
  output logic              hit,
  output logic [4:0]        code
);

  logic [NUM_FMT-1:0] hit_vec;
  logic [4:0]         code_vec [NUM_FMT];

  generate
    for (genvar g = 0; g < NUM_FMT; g++) begin : g_ent
      localparam int         LN = ref_lines(g) / LINE_DIV;
      localparam int         WD = ref_words(g) / WORD_DIV;
      localparam logic [4:0] CD = ref_code(g);
      logic allowed;
      assign allowed    = ((fmt_sel == 5'd0) || (fmt_sel == CD)) &&
                          !(hd_only && !CD[4]) && !(sd_only && CD[4]);
      assign hit_vec[g]  = allowed && (lines == LCNT_W'(LN)) && (words == WCNT_W'(WD));
      assign code_vec[g] = hit_vec[g] ? CD : 5'd0;
    end
  endgenerate

  always_comb begin
    hit  = |hit_vec;
    code = 5'd0;
    for (int i = 0; i < NUM_FMT; i++) code = code | code_vec[i];
  end

endmodule

// File: rtl/vfd_raster_detect.sv
module vfd_raster_detect
  import vfd_pkg::*;
#(
  parameter int WORD_DIV = 1,
  parameter int LINE_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vid_valid,
  input  logic [9:0] vid_data,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [6:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [4:0] fmt_code,
  output logic       locked,
  output logic       flag_h,
  output logic       flag_v,
  output logic       flag_f
);

  localparam int WCNT_W = $clog2(max_words() / WORD_DIV + 2);
  localparam int LCNT_W = $clog2(max_lines() / LINE_DIV + 2);

  logic              trs_hit;
  trs_flags_t        trs_flags;
  logic              frm_stb;
  logic [LCNT_W-1:0] frm_lines, prev_lines;
  logic [WCNT_W-1:0] frm_words, prev_words;
  logic              m_hit;
  logic [4:0]        m_code;
  logic [4:0]        fmt_sel;
  logic              hd_only, sd_only;
  logic              cfg_wr;
  logic              same;
  acq_t              acq;

  vfd_trs_detect u_trs (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (vid_valid),
    .word    (vid_data),
    .trs_hit (trs_hit),
    .flags   (trs_flags)
  );

  vfd_geom #(.WCNT_W(WCNT_W), .LCNT_W(LCNT_W)) u_geom (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld       (vid_valid),
    .trs_hit   (trs_hit),
    .flags     (trs_flags),
    .frm_stb   (frm_stb),
    .frm_lines (frm_lines),
    .frm_words (frm_words)
  );

  vfd_match #(.WORD_DIV(WORD_DIV), .LINE_DIV(LINE_DIV), .WCNT_W(WCNT_W), .LCNT_W(LCNT_W)) u_match (
    .lines   (frm_lines),
    .words   (frm_words),
    .fmt_sel (fmt_sel),
    .hd_only (hd_only),
    .sd_only (sd_only),
    .hit     (m_hit),
    .code    (m_code)
  );

  assign cfg_wr = reg_wr && (reg_addr == REG_CTRL);
  assign same   = (acq == ACQ_TRACK) && (frm_lines == prev_lines) && (frm_words == prev_words);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_sel <= '0;
      hd_only <= 1'b0;
      sd_only <= 1'b0;
    end else if (cfg_wr) begin
      {sd_only, hd_only, fmt_sel} <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq        <= ACQ_WAIT;
      prev_lines <= '0;
      prev_words <= '0;
      locked     <= 1'b0;
      fmt_code   <= '0;
    end else if (cfg_wr) begin
      acq      <= ACQ_WAIT;
      locked   <= 1'b0;
      fmt_code <= '0;
    end else if (frm_stb) begin
      if (acq == ACQ_WAIT) begin
        acq <= ACQ_ARMED;
      end else begin
        acq        <= ACQ_TRACK;
        prev_lines <= frm_lines;
        prev_words <= frm_words;
        locked     <= same && m_hit;
        fmt_code   <= (same && m_hit) ? m_code : 5'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       {flag_f, flag_v, flag_h} <= 3'b000;
    else if (trs_hit) {flag_f, flag_v, flag_h} <= trs_flags;
  end

  assign reg_rdata = (reg_addr == REG_CTRL) ? {1'b0, sd_only, hd_only, fmt_sel}
                                            : {flag_f, flag_v, flag_h, fmt_code};

endmodule

// File: rtl/vfd_raster_detect_chk.sv
module vfd_raster_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       frm_stb,
  input logic       trs_hit,
  input logic       locked,
  input logic [4:0] fmt_code,
  input logic [4:0] fmt_sel,
  input logic       hd_only,
  input logic       sd_only,
  input logic       flag_h,
  input logic       flag_v,
  input logic       flag_f
);

  // R5: a lock always carries a table code (all codes are nonzero)
  assert_lock_has_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (fmt_code != 5'd0));

  // R5: lock only moves on a frame start or a control write
  assert_lock_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frm_stb) && !$past(cfg_wr)) |-> $stable(locked));

  // R6: without lock the code reads zero
  assert_unlocked_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (fmt_code == 5'd0));

  // R7: a pinned format only ever reports that format
  assert_single_fmt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && (fmt_sel != 5'd0)) |-> (fmt_code == fmt_sel));

  // R8: family limits
  assert_sd_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && sd_only) |-> !fmt_code[4]);
  assert_hd_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && hd_only) |-> fmt_code[4]);

  // R10: a control write drops lock on its edge
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !locked);

  // R2: flags hold between sequences
  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(trs_hit) |-> $stable({flag_f, flag_v, flag_h}));

endmodule

bind vfd_raster_detect vfd_raster_detect_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .frm_stb  (frm_stb),
  .trs_hit  (trs_hit),
  .locked   (locked),
  .fmt_code (fmt_code),
  .fmt_sel  (fmt_sel),
  .hd_only  (hd_only),
  .sd_only  (sd_only),
  .flag_h   (flag_h),
  .flag_v   (flag_v),
  .flag_f   (flag_f)
);

// File: tb/vfd_raster_detect_tb_top.sv
module vfd_raster_detect_tb_top;

  localparam int WDIV = 50;
  localparam int LDIV = 25;

  localparam int L525 = 525 / LDIV,  W1716 = 1716 / WDIV;
  localparam int L625 = 625 / LDIV,  W1728 = 1728 / WDIV;
  localparam int L1125 = 1125 / LDIV, W2200 = 2200 / WDIV, W2640 = 2640 / WDIV;
  localparam int L750 = 750 / LDIV,  W1650 = 1650 / WDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vid_valid = 1'b0;
  logic [9:0] vid_data = '0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [6:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [4:0] fmt_code;
  logic       locked, flag_h, flag_v, flag_f;

  always #10 clk = ~clk;

  vfd_raster_detect #(.WORD_DIV(WDIV), .LINE_DIV(LDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_data(vid_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fmt_code(fmt_code), .locked(locked), .flag_h(flag_h), .flag_v(flag_v), .flag_f(flag_f)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int push_n = 0;

  // reference table
  int         tab_l [5] = '{525, 625, 1125, 1125, 750};
  int         tab_w [5] = '{1716, 1728, 2200, 2640, 1650};
  logic [4:0] tab_c [5] = '{5'b00011, 5'b01011, 5'b10010, 5'b11010, 5'b10100};

  // behavioural model state
  int         m_w1, m_w2, m_w3, m_wc, m_len, m_lc, m_stage, m_pl, m_pw;
  bit         m_lastv, m_lk, m_hd, m_sd, m_h, m_v, m_f;
  logic [4:0] m_fs, m_code;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] mdl_lookup(int l, int w);
    for (int i = 0; i < 5; i++) begin
      if (l == tab_l[i] / LDIV && w == tab_w[i] / WDIV &&
          (m_fs == 5'd0 || m_fs == tab_c[i]) &&
          !(m_hd && !tab_c[i][4]) && !(m_sd && tab_c[i][4]))
        return tab_c[i];
    end
    return 5'd0;
  endfunction

  task automatic model_step();
    bit trs, eav, bnd, same;
    int nlen, nlc;
    logic [4:0] c;
    if (!rst_n) begin
      m_w1 = 0; m_w2 = 0; m_w3 = 0; m_wc = 0; m_len = 0; m_lc = 0;
      m_stage = 0; m_pl = 0; m_pw = 0; m_lastv = 0; m_lk = 0; m_code = 0;
      m_fs = 0; m_hd = 0; m_sd = 0; m_h = 0; m_v = 0; m_f = 0;
      return;
    end
    trs  = vid_valid && m_w3 == 1023 && m_w2 == 0 && m_w1 == 0;
    eav  = trs && vid_data[6];
    bnd  = trs && m_lastv && !vid_data[7] && !vid_data[8];
    nlen = eav ? m_wc + 1 : m_len;
    nlc  = eav ? m_lc + 1 : m_lc;
    if (vid_valid) m_wc = eav ? 0 : m_wc + 1;
    m_len = nlen;
    m_lc  = bnd ? 0 : nlc;
    if (trs) begin
      m_lastv = vid_data[7];
      m_h = vid_data[6]; m_v = vid_data[7]; m_f = vid_data[8];
    end
    if (vid_valid) begin
      m_w3 = m_w2; m_w2 = m_w1; m_w1 = int'(vid_data);
    end
    if (reg_wr && reg_addr == 1'b0) begin
      m_fs = reg_wdata[4:0]; m_hd = reg_wdata[5]; m_sd = reg_wdata[6];
      m_stage = 0; m_lk = 0; m_code = 0;
    end else if (bnd) begin
      if (m_stage == 0) m_stage = 1;
      else begin
        c    = mdl_lookup(nlc, nlen);
        same = (m_stage == 2) && nlc == m_pl && nlen == m_pw;
        m_lk = same && (c != 5'd0);
        m_code = m_lk ? c : 5'd0;
        m_pl = nlc; m_pw = nlen; m_stage = 2;
      end
    end
  endtask

  task automatic compare();
    logic [7:0] er;
    er = reg_addr ? {m_f, m_v, m_h, m_code} : {1'b0, m_sd, m_hd, m_fs};
    chk("R5 locked vs model", int'(locked), int'(m_lk));
    chk("R6 fmt_code vs model", int'(fmt_code), int'(m_code));
    chk("R2 flags vs model", int'({flag_f, flag_v, flag_h}), int'({m_f, m_v, m_h}));
    chk("R9 reg_rdata vs model", int'(reg_rdata), int'(er));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #5;
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      vid_valid = 1'b0; vid_data = 10'h3FF; reg_wr = 1'b0;
      tick();
    end
  endtask

  task automatic push(logic [9:0] w);
    if (push_n % 7 == 6) idle(1);   // gap with preamble-like junk
    push_n++;
    vid_valid = 1'b1; vid_data = w; reg_wr = 1'b0;
    tick();
  endtask

  task automatic wr_reg(logic a, logic [6:0] d);
    vid_valid = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic send_line(int w, bit f, bit v);
    push(10'h3FF); push(10'h000); push(10'h000); push({1'b1, f, v, 1'b1, 6'd0});
    for (int i = 4; i < w / 2; i++) push(i[0] ? 10'h200 : 10'h040);
    push(10'h3FF); push(10'h000); push(10'h000); push({1'b1, f, v, 1'b0, 6'd0});
    for (int i = w / 2 + 4; i < w; i++) push(i[0] ? 10'h200 : 10'h040);
  endtask

  task automatic send_frame(int l, int w, bit il);
    for (int ln = 0; ln < l; ln++) begin
      bit f, v;
      f = il && (ln >= l / 2);
      v = (ln < 2) || (il && ln >= l / 2 && ln < l / 2 + 2);
      send_line(w, f, v);
    end
  endtask

  task automatic frames(int n, int l, int w, bit il);
    for (int k = 0; k < n; k++) send_frame(l, w, il);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    reg_addr = 1'b0;
    idle(1);
    chk("R1 reset locked", int'(locked), 0);
    chk("R1 reset code", int'(fmt_code), 0);
    chk("R1 reset ctrl reg", int'(reg_rdata), 0);
    reg_addr = 1'b1;
    idle(1);
    chk("R1 reset status reg", int'(reg_rdata), 0);

    // R2: flag capture and hold
    push(10'h3FF); push(10'h000); push(10'h000); push(10'h3C0);
    chk("R2 H from bit 6", int'(flag_h), 1);
    chk("R2 V from bit 7", int'(flag_v), 1);
    chk("R2 F from bit 8", int'(flag_f), 1);
    push(10'h040); push(10'h200);
    chk("R2 flags held", int'({flag_f, flag_v, flag_h}), 7);

    // R3/R4/R5: auto detection of every entry
    frames(3, L525, W1716, 1'b1);
    chk("R5 lock 525", int'(locked), 1);
    chk("R4 code 525", int'(fmt_code), 5'b00011);
    chk("R3 gaps not counted", int'(reg_rdata[4:0]), 5'b00011);
    frames(3, L1125, W2640, 1'b1);
    chk("R4 code 1125x2640", int'(fmt_code), 5'b11010);
    frames(3, L750, W1650, 1'b0);
    chk("R4 code 750", int'(fmt_code), 5'b10100);
    frames(3, L1125, W2200, 1'b1);
    chk("R4 code 1125x2200", int'(fmt_code), 5'b10010);
    frames(3, L625, W1728, 1'b1);
    chk("R4 code 625", int'(fmt_code), 5'b01011);

    // R6: one odd frame drops, then relock
    send_frame(L625 + 1, W1728, 1'b1);
    send_frame(L625, W1728, 1'b1);
    chk("R6 drop locked", int'(locked), 0);
    chk("R6 drop code", int'(fmt_code), 0);
    frames(2, L625, W1728, 1'b1);
    chk("R6 relock", int'(locked), 1);

    // R9: offset 1 ignores writes
    wr_reg(1'b1, 7'h7F);
    chk("R9 status write ignored lock", int'(locked), 1);
    reg_addr = 1'b0;
    idle(1);
    chk("R9 ctrl unchanged", int'(reg_rdata), 0);

    // R10 + R7: pin to 525 code
    wr_reg(1'b0, 7'h03);
    chk("R10 write clears lock", int'(locked), 0);
    idle(1);
    chk("R9 ctrl readback", int'(reg_rdata), 8'h03);
    reg_addr = 1'b1;
    frames(3, L625, W1728, 1'b1);
    chk("R7 other format rejected", int'(locked), 0);
    frames(3, L525, W1716, 1'b1);
    chk("R7 pinned format locks", int'(fmt_code), 5'b00011);

    // R8: family limits
    wr_reg(1'b0, 7'h20);
    frames(3, L525, W1716, 1'b1);
    chk("R8 hd-only rejects SD", int'(locked), 0);
    frames(3, L750, W1650, 1'b0);
    chk("R8 hd-only accepts HD", int'(fmt_code), 5'b10100);
    wr_reg(1'b0, 7'h40);
    frames(3, L1125, W2200, 1'b1);
    chk("R8 sd-only rejects HD", int'(locked), 0);
    frames(3, L625, W1728, 1'b1);
    chk("R8 sd-only accepts SD", int'(fmt_code), 5'b01011);
    wr_reg(1'b0, 7'h60);
    frames(3, L525, W1716, 1'b1);
    chk("R8 both bits reject all", int'(locked), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog expired act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule